// File: doc/BRIEF.md
# I2C-Tunnelled SPI Flash Bridge

This block is an I2C target, working at the byte layer, that lets an external host drive the SPI bus of a flash device. A separate bit-level I2C front end reports a start, an address with its direction bit, each byte written by the host, each request for a read byte, and the stop. The bridge answers these events, decodes commands and runs a mode 0 SPI shifter toward the flash.

After reset the bridge is locked. While locked it ignores every command and every read returns 0xFF. A fixed unlock key must arrive as the only content of one write transaction, closed by a stop. Once unlocked, the first byte of each write transaction is a command. Command 0x10 keeps chip select asserted and exchanges each following byte of the transaction over SPI. Every received byte lands in an internal state register. Other commands report status, give the two bytes of a running CRC-16, clear that CRC, or lock the bridge again.

The CRC is fed with the state register's content at the moment each 0x10 data byte arrives. That content is the byte received in the previous exchange, not the byte the host just sent.

Top module: `i2c_spi_bridge`

## Requirements
- R1: The bridge acknowledges only the 7-bit address 0x49, with `i2c_ack` high for one cycle, one cycle after `i2c_addr_valid`; any other address gives no acknowledge.
- R2: While locked, no command has an effect: a 0x10 transaction never lowers `spi_cs_n` and never toggles `spi_sclk`.
- R3: The bridge unlocks only when one write transaction carries exactly the key bytes (default ASCII "ISPGO") and then ends with a stop. A wrong byte, a key split over two transactions, or an extra byte leaves it locked.
- R4: After command 0x10, each further byte of the same write transaction is shifted out on `spi_mosi` MSB first in SPI mode 0. `spi_cs_n` goes low when the command byte arrives and returns high after the stop, once the shift in flight has completed.
- R5: The byte sampled on `spi_miso` during each exchange is stored in the state register, which resets to 0x00.
- R6: The CRC starts at 0xFFFF and uses polynomial 0x8005, MSB first, not reflected. It changes only on a 0x10 data byte, and is then fed the state register value held before that byte's exchange.
- R7: A read after command 0x20 returns a status byte first: bit 0 is 1 (unlocked) and bit 1 is 1 while chip select is asserted.
- R8: A read after command 0x22 returns the CRC high byte first; after command 0x23 it returns the CRC low byte first.
- R9: Command 0x21 sets the CRC to 0xFFFF and defines no read bytes.
- R10: Any read byte past a command's defined length (one byte for 0x20, 0x22 and 0x23; none for others) returns the state register.
- R11: Command 0x24 locks the bridge again; while locked every read byte is 0xFF, and each `i2c_rd_req` is answered by `i2c_rd_valid` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| i2c_start | input | 1 | Start or repeated start seen (pulse) |
| i2c_addr_valid | input | 1 | Address byte received (pulse) |
| i2c_addr | input | 7 | Received 7-bit address |
| i2c_rw | input | 1 | Direction bit, 1 = host reads |
| i2c_wr_valid | input | 1 | Host wrote a data byte (pulse) |
| i2c_wr_data | input | 8 | Data byte written by the host |
| i2c_rd_req | input | 1 | Host asks for a read byte (pulse) |
| i2c_stop | input | 1 | Stop condition seen (pulse) |
| i2c_ack | output | 1 | Address matched this target (pulse) |
| i2c_rd_valid | output | 1 | Read byte ready (pulse) |
| i2c_rd_data | output | 8 | Read byte |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sclk | output | 1 | SPI clock, idle low |
| spi_mosi | output | 1 | SPI data toward the flash |
| spi_miso | input | 1 | SPI data from the flash |

## Verification
`i2c_ack` and `i2c_rd_valid` come from one register each, so the bench drives events on the falling clock edge and samples them at the next falling edge. An SPI exchange takes 16 × SCK_DIV cycles after its byte is accepted. The bench therefore allows 50 cycles per byte before the next event. It also waits a fixed margin after each stop before it checks `spi_cs_n`, the state register or the CRC. A flash model in the bench checks each MOSI bit and produces each MISO bit on the SPI clock edges. The expected CRC is computed in the bench from the order in which it hands out MISO bytes.

// File: rtl/spi_bridge_pkg.sv
// Shared command codes and the CRC-16 byte step for the I2C-to-SPI bridge.
package spi_bridge_pkg;

    typedef enum logic [7:0] {
        OP_XFER   = 8'h10,
        OP_STAT   = 8'h20,
        OP_CRCCLR = 8'h21,
        OP_CRCHI  = 8'h22,
        OP_CRCLO  = 8'h23,
        OP_EXIT   = 8'h24
    } op_e;

    localparam logic [15:0] CRC_POLY = 16'h8005;
    localparam logic [15:0] CRC_INIT = 16'hFFFF;

    // Advance an MSB-first, unreflected CRC-16 by one data byte.
    function automatic logic [15:0] crc16_step(input logic [15:0] c_in,
                                               input logic [7:0]  d);
        logic [15:0] c;
        logic        fb;
        c = c_in;
        for (int i = 7; i >= 0; i--) begin
            fb = c[15] ^ d[i];
            c  = {c[14:0], 1'b0};
            if (fb) c = c ^ CRC_POLY;
        end
        return c;
    endfunction

endpackage

// File: rtl/spi_bridge_unlock.sv
// Key detector. While locked it watches each transaction addressed to the
// bridge. It unlocks when a write transaction holds exactly the key bytes
// and ends with a stop. Assumes the caller passes only events for this target.
module spi_bridge_unlock #(
    parameter int              LEN = 5,
    parameter logic [8*LEN-1:0] KEY = "ISPGO"
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       txn_begin,
    input  logic       txn_is_write,
    input  logic       byte_valid,
    input  logic [7:0] byte_data,
    input  logic       txn_end,
    input  logic       relock,
    output logic       unlocked
);
    localparam int IW = $clog2(LEN + 1);

    logic [IW-1:0] idx;
    logic          ok;
    logic          live;
    logic [7:0]    exp_byte;

    // Select the key byte expected at the current position.
    always_comb begin
        exp_byte = 8'h00;
        for (int k = 0; k < LEN; k++)
            if (idx == IW'(k)) exp_byte = KEY[8*(LEN-1-k) +: 8];
    end

    // Track key progress per transaction and set or clear the lock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx      <= '0;
            ok       <= 1'b0;
            live     <= 1'b0;
            unlocked <= 1'b0;
        end else if (relock) begin
            unlocked <= 1'b0;
            live     <= 1'b0;
        end else if (!unlocked) begin
            if (txn_begin) begin
                live <= 1'b1;
                ok   <= txn_is_write;
                idx  <= '0;
            end else if (live && byte_valid) begin
                if (idx < IW'(LEN) && byte_data == exp_byte) idx <= idx + 1'b1;
                else                                        ok  <= 1'b0;
            end else if (live && txn_end) begin
                live <= 1'b0;
                if (ok && idx == IW'(LEN)) unlocked <= 1'b1;
            end
        end
    end

    // R3
    unlock_on_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked) |-> $past(txn_end));

endmodule

// File: rtl/spi_bridge_shifter.sv
// Mode 0 SPI byte shifter. SCLK idles low, MOSI leads each rising edge,
// MISO is sampled on the rising edge, and the next bit is presented on the
// falling edge. Each half period lasts DIV system clocks. A start while busy
// is ignored.
module spi_bridge_shifter #(
    parameter int DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic       busy,
    output logic       done,
    output logic [7:0] rx_byte
);
    localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [DW-1:0] div_cnt;
    logic [3:0]    half;
    logic [7:0]    sh_tx;
    logic [7:0]    sh_rx;

    assign mosi = sh_tx[7];

    // Run the half-period timer and shift bits on the SCLK edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_cnt <= '0;
            half    <= '0;
            sh_tx   <= '0;
            sh_rx   <= '0;
            sclk    <= 1'b0;
            busy    <= 1'b0;
            done    <= 1'b0;
            rx_byte <= '0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy    <= 1'b1;
                    sh_tx   <= tx_byte;
                    div_cnt <= '0;
                    half    <= '0;
                end
            end else if (div_cnt == DW'(DIV - 1)) begin
                div_cnt <= '0;
                half    <= half + 1'b1;
                if (!sclk) begin
                    sclk  <= 1'b1;
                    sh_rx <= {sh_rx[6:0], miso};
                end else begin
                    sclk  <= 1'b0;
                    sh_tx <= {sh_tx[6:0], 1'b0};
                    if (half == 4'd15) begin
                        busy    <= 1'b0;
                        done    <= 1'b1;
                        rx_byte <= sh_rx;
                    end
                end
            end else begin
                div_cnt <= div_cnt + 1'b1;
            end
        end
    end

    // R4
    sclk_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sclk);

endmodule

// File: rtl/spi_bridge_crc.sv
// CRC-16 register over the SPI traffic. A clear has priority over an update;
// an update folds in one byte. Assumes at most one event per cycle.
module spi_bridge_crc
    import spi_bridge_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        upd,
    input  logic        clr,
    input  logic [7:0]  din,
    output logic [15:0] crc
);
    // Hold, clear or advance the running CRC.
    always_ff @(posedge clk) begin
        if (!rst_n)   crc <= CRC_INIT;
        else if (clr) crc <= CRC_INIT;
        else if (upd) crc <= crc16_step(crc, din);
    end

    // R6
    crc_moves_on_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(crc) |-> $past(upd || clr));

endmodule

// File: rtl/i2c_spi_bridge.sv
// Top of the I2C-to-SPI flash bridge. Decodes byte-layer I2C events into
// commands, drives chip select and the SPI shifter, keeps the state register
// and serves read bytes. Assumes the host leaves at least 16*SCK_DIV+4 cycles
// between two 0x10 data bytes. No clock stretching is provided.
module i2c_spi_bridge
    import spi_bridge_pkg::*;
#(
    parameter logic [6:0]           DEV_ADDR = 7'h49,
    parameter int                   SCK_DIV  = 2,
    parameter int                   KEY_LEN  = 5,
    parameter logic [8*KEY_LEN-1:0] KEY      = "ISPGO"
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       i2c_start,
    input  logic       i2c_addr_valid,
    input  logic [6:0] i2c_addr,
    input  logic       i2c_rw,
    input  logic       i2c_wr_valid,
    input  logic [7:0] i2c_wr_data,
    input  logic       i2c_rd_req,
    input  logic       i2c_stop,
    output logic       i2c_ack,
    output logic       i2c_rd_valid,
    output logic [7:0] i2c_rd_data,
    output logic       spi_cs_n,
    output logic       spi_sclk,
    output logic       spi_mosi,
    input  logic       spi_miso
);
    logic        unlocked;
    logic        sel, is_rd, first, xfer, past_first, rel_pend;
    logic [7:0]  cmd_q, state_q, rd_field;
    logic [15:0] crc;
    logic        spi_busy, spi_done;
    logic [7:0]  spi_rx;
    logic        addr_hit, wr_ok, wr_live, is_cmd;
    logic        spi_go, crc_clr, relock;

    // Qualify the incoming byte events for this target.
    always_comb begin
        addr_hit = i2c_addr_valid && (i2c_addr == DEV_ADDR);
        wr_ok    = i2c_wr_valid && sel && !is_rd;
        wr_live  = wr_ok && unlocked;
        is_cmd   = wr_live && first;
        spi_go   = wr_live && !first && xfer;
        crc_clr  = is_cmd && (i2c_wr_data == OP_CRCCLR);
        relock   = is_cmd && (i2c_wr_data == OP_EXIT);
    end

    // Choose the byte returned to a read request.
    always_comb begin
        if (!unlocked)                           rd_field = 8'hFF;
        else if (!past_first && cmd_q == OP_STAT)  rd_field = {6'b0, ~spi_cs_n, 1'b1};
        else if (!past_first && cmd_q == OP_CRCHI) rd_field = crc[15:8];
        else if (!past_first && cmd_q == OP_CRCLO) rd_field = crc[7:0];
        else                                      rd_field = state_q;
    end

    spi_bridge_unlock #(.LEN(KEY_LEN), .KEY(KEY)) u_unlock (
        .clk          (clk),
        .rst_n        (rst_n),
        .txn_begin    (addr_hit),
        .txn_is_write (!i2c_rw),
        .byte_valid   (wr_ok),
        .byte_data    (i2c_wr_data),
        .txn_end      (i2c_stop && sel),
        .relock       (relock),
        .unlocked     (unlocked)
    );

    spi_bridge_shifter #(.DIV(SCK_DIV)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (spi_go),
        .tx_byte (i2c_wr_data),
        .miso    (spi_miso),
        .sclk    (spi_sclk),
        .mosi    (spi_mosi),
        .busy    (spi_busy),
        .done    (spi_done),
        .rx_byte (spi_rx)
    );

    spi_bridge_crc u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .upd   (spi_go),
        .clr   (crc_clr),
        .din   (state_q),
        .crc   (crc)
    );

    // Follow the I2C transaction framing and latch the command byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel        <= 1'b0;
            is_rd      <= 1'b0;
            first      <= 1'b0;
            xfer       <= 1'b0;
            past_first <= 1'b0;
            cmd_q      <= 8'h00;
            i2c_ack    <= 1'b0;
        end else begin
            i2c_ack <= addr_hit;
            if (i2c_start || i2c_stop) begin
                sel  <= 1'b0;
                xfer <= 1'b0;
            end else if (i2c_addr_valid) begin
                sel        <= addr_hit;
                is_rd      <= i2c_rw;
                first      <= 1'b1;
                past_first <= 1'b0;
                xfer       <= 1'b0;
            end else if (is_cmd) begin
                first <= 1'b0;
                cmd_q <= i2c_wr_data;
                xfer  <= (i2c_wr_data == OP_XFER);
            end else if (i2c_rd_req && sel && is_rd) begin
                past_first <= 1'b1;
            end
        end
    end

    // Serve read bytes one cycle after each request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            i2c_rd_valid <= 1'b0;
            i2c_rd_data  <= 8'h00;
        end else begin
            i2c_rd_valid <= i2c_rd_req && sel && is_rd;
            if (i2c_rd_req && sel && is_rd) i2c_rd_data <= rd_field;
        end
    end

    // Capture each byte received from the flash.
    always_ff @(posedge clk) begin
        if (!rst_n)        state_q <= 8'h00;
        else if (spi_done) state_q <= spi_rx;
    end

    // Assert chip select on 0x10; release it after stop once the shifter is idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spi_cs_n <= 1'b1;
            rel_pend <= 1'b0;
        end else if (is_cmd && i2c_wr_data == OP_XFER) begin
            spi_cs_n <= 1'b0;
            rel_pend <= 1'b0;
        end else if ((i2c_stop && sel) || rel_pend) begin
            if (spi_busy) rel_pend <= 1'b1;
            else begin
                spi_cs_n <= 1'b1;
                rel_pend <= 1'b0;
            end
        end
    end

    // R1
    ack_only_own_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        i2c_ack |-> $past(i2c_addr_valid && i2c_addr == DEV_ADDR));

    // R2
    cs_needs_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_cs_n) |-> $past(unlocked));

    // R4
    sclk_inside_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sclk |-> !spi_cs_n);

    // R11
    rd_reply_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        i2c_rd_valid |-> $past(i2c_rd_req));

endmodule

// File: tb/i2c_spi_bridge_bench.sv
module i2c_spi_bridge_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       i2c_start = 0, i2c_addr_valid = 0, i2c_rw = 0;
    logic [6:0] i2c_addr = '0;
    logic       i2c_wr_valid = 0, i2c_rd_req = 0, i2c_stop = 0;
    logic [7:0] i2c_wr_data = '0;
    logic       i2c_ack, i2c_rd_valid;
    logic [7:0] i2c_rd_data;
    logic       spi_cs_n, spi_sclk, spi_mosi;
    logic       spi_miso = 1'b0;

    int total = 0, bad = 0;
    logic [7:0] wbuf [16];
    logic [7:0] rbuf [4];
    logic       ack_seen;

    // flash model state
    int         resp_n = 0, bitc = 0;
    logic [7:0] cur = '0;
    logic [7:0] mosi_sh = '0;
    int         mosi_bits = 0, mosi_cnt = 0;
    logic [7:0] mosi_log [256];
    int         cs_falls = 0, sclk_rises = 0;

    // bench model
    logic [15:0] exp_crc = 16'hFFFF;
    logic [7:0]  exp_state = 8'h00;
    int          exp_n = 0;

    always #10 clk = ~clk;

    i2c_spi_bridge u_i2c_spi_bridge (
        .clk(clk), .rst_n(rst_n), .i2c_start(i2c_start),
        .i2c_addr_valid(i2c_addr_valid), .i2c_addr(i2c_addr), .i2c_rw(i2c_rw),
        .i2c_wr_valid(i2c_wr_valid), .i2c_wr_data(i2c_wr_data),
        .i2c_rd_req(i2c_rd_req), .i2c_stop(i2c_stop), .i2c_ack(i2c_ack),
        .i2c_rd_valid(i2c_rd_valid), .i2c_rd_data(i2c_rd_data),
        .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso)
    );

    function automatic logic [7:0] resp(input int n);
        logic [7:0] v;
        v = 8'(n * 29 + 7);
        return v ^ 8'h5A;
    endfunction

    function automatic logic [15:0] ref_crc(input logic [15:0] c0, input logic [7:0] d);
        logic [15:0] c;
        c = c0 ^ {d, 8'h00};
        for (int i = 0; i < 8; i++)
            c = c[15] ? ((c << 1) ^ 16'h8005) : (c << 1);
        return c;
    endfunction

    // flash: present bits before rising edges, capture MOSI on rising edges
    always @(negedge spi_cs_n) begin
        cs_falls <= cs_falls + 1;
        bitc     <= 0;
        cur      <= resp(resp_n);
        spi_miso <= resp(resp_n)[7];
    end
    always @(negedge spi_sclk) begin
        if (bitc == 7) begin
            bitc     <= 0;
            resp_n   <= resp_n + 1;
            cur      <= resp(resp_n + 1);
            spi_miso <= resp(resp_n + 1)[7];
        end else begin
            bitc     <= bitc + 1;
            spi_miso <= cur[6 - bitc];
        end
    end
    always @(posedge spi_sclk) begin
        sclk_rises <= sclk_rises + 1;
        if (mosi_bits == 7) begin
            mosi_log[mosi_cnt[7:0]] <= {mosi_sh[6:0], spi_mosi};
            mosi_cnt  <= mosi_cnt + 1;
            mosi_bits <= 0;
        end else begin
            mosi_bits <= mosi_bits + 1;
        end
        mosi_sh <= {mosi_sh[6:0], spi_mosi};
    end

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic addr_phase(input logic [6:0] a, input logic rw);
        @(negedge clk); i2c_start = 1;
        @(negedge clk); i2c_start = 0; i2c_addr_valid = 1; i2c_addr = a; i2c_rw = rw;
        @(negedge clk); i2c_addr_valid = 0; ack_seen = i2c_ack;
    endtask

    task automatic i2c_wr(input logic [6:0] a, input int n);
        addr_phase(a, 1'b0);
        for (int i = 0; i < n; i++) begin
            i2c_wr_valid = 1; i2c_wr_data = wbuf[i];
            @(negedge clk); i2c_wr_valid = 0;
            cyc(50);
        end
        i2c_stop = 1;
        @(negedge clk); i2c_stop = 0;
        cyc(50);
    endtask

    task automatic i2c_rd(input logic [6:0] a, input int n);
        addr_phase(a, 1'b1);
        for (int i = 0; i < n; i++) begin
            i2c_rd_req = 1;
            @(negedge clk); i2c_rd_req = 0;
            check8("R11 rd_valid", {7'b0, i2c_rd_valid}, 8'h01);
            rbuf[i] = i2c_rd_data;
            cyc(3);
        end
        i2c_stop = 1;
        @(negedge clk); i2c_stop = 0;
        cyc(3);
    endtask

    task automatic cmd_only(input logic [7:0] c);
        wbuf[0] = c;
        i2c_wr(7'h49, 1);
    endtask

    task automatic load_key();
        wbuf[0] = "I"; wbuf[1] = "S"; wbuf[2] = "P"; wbuf[3] = "G"; wbuf[4] = "O";
    endtask

    // 0x10 with n bytes starting at seed; updates the model and checks MOSI and CS
    task automatic xfer(input int n, input logic [7:0] seed);
        int base;
        base = mosi_cnt;
        wbuf[0] = 8'h10;
        for (int i = 0; i < n; i++) wbuf[i+1] = 8'(seed + i * 8'h35);
        addr_phase(7'h49, 1'b0);
        for (int i = 0; i <= n; i++) begin
            i2c_wr_valid = 1; i2c_wr_data = wbuf[i];
            @(negedge clk); i2c_wr_valid = 0;
            if (i == 0) check8("R4 cs low after 0x10", {7'b0, spi_cs_n}, 8'h00);
            cyc(50);
        end
        for (int i = 0; i < n; i++) begin
            exp_crc   = ref_crc(exp_crc, exp_state);
            exp_state = resp(exp_n);
            exp_n++;
        end
        check8("R4 cs held before stop", {7'b0, spi_cs_n}, 8'h00);
        i2c_stop = 1;
        @(negedge clk); i2c_stop = 0;
        cyc(50);
        check8("R4 cs released", {7'b0, spi_cs_n}, 8'h01);
        for (int i = 0; i < n; i++)
            check8("R4 mosi byte", mosi_log[8'(base + i)], wbuf[i+1]);
    endtask

    task automatic read_crc();
        cmd_only(8'h22); i2c_rd(7'h49, 1); check8("R8 crc hi", rbuf[0], exp_crc[15:8]);
        cmd_only(8'h23); i2c_rd(7'h49, 1); check8("R8 crc lo", rbuf[0], exp_crc[7:0]);
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=finished");
        summary();
    end

    initial begin
        cyc(4);
        check8("R4 reset cs_n", {7'b0, spi_cs_n}, 8'h01);
        check8("R4 reset sclk", {7'b0, spi_sclk}, 8'h00);
        rst_n = 1;
        cyc(2);

        // R1 address sweep around own address
        for (int a = 8'h40; a < 8'h52; a++) begin
            addr_phase(7'(a), 1'b1);
            i2c_stop = 1; @(negedge clk); i2c_stop = 0;
            check8("R1 ack", {7'b0, ack_seen}, (a == 8'h49) ? 8'h01 : 8'h00);
        end

        // R2 locked: 0x10 has no SPI effect; R11 reads give FF
        wbuf[0] = 8'h10; wbuf[1] = 8'hAA;
        i2c_wr(7'h49, 2);
        check8("R2 no cs while locked", 8'(cs_falls), 8'h00);
        check8("R2 no sclk while locked", 8'(sclk_rises), 8'h00);
        i2c_rd(7'h49, 2);
        check8("R11 locked read", rbuf[0], 8'hFF);
        check8("R11 locked read 2", rbuf[1], 8'hFF);

        // R3 wrong key, split key, extra byte
        load_key(); wbuf[2] = "X";
        i2c_wr(7'h49, 5);
        i2c_rd(7'h49, 1); check8("R3 wrong key stays locked", rbuf[0], 8'hFF);
        load_key(); i2c_wr(7'h49, 3);
        wbuf[0] = "G"; wbuf[1] = "O"; i2c_wr(7'h49, 2);
        i2c_rd(7'h49, 1); check8("R3 split key stays locked", rbuf[0], 8'hFF);
        load_key(); wbuf[5] = "!";
        i2c_wr(7'h49, 6);
        i2c_rd(7'h49, 1); check8("R3 long key stays locked", rbuf[0], 8'hFF);
        load_key(); i2c_wr(7'h48, 5);
        i2c_rd(7'h49, 1); check8("R3 key to other addr", rbuf[0], 8'hFF);
        load_key(); i2c_wr(7'h49, 5);
        i2c_rd(7'h49, 1); check8("R3 R5 unlocked state reset", rbuf[0], 8'h00);

        // R7 status, R10 past length
        cmd_only(8'h20); i2c_rd(7'h49, 2);
        check8("R7 status", rbuf[0], 8'h01);
        check8("R10 past status", rbuf[1], 8'h00);
        read_crc();

        // R4 R5 R6 transfers of several sizes and patterns
        for (int t = 0; t < 4; t++) begin
            xfer(t + 2, 8'(t * 8'h4B + 8'h01));
            cmd_only(8'h10); i2c_rd(7'h49, 1);
            check8("R5 state after xfer", rbuf[0], exp_state);
            read_crc();
        end

        // R10 read beyond one-byte length
        cmd_only(8'h22); i2c_rd(7'h49, 3);
        check8("R8 hi first", rbuf[0], exp_crc[15:8]);
        check8("R10 beyond hi", rbuf[1], exp_state);
        check8("R10 beyond hi 2", rbuf[2], exp_state);

        // R9 clear, then 0x21 reads return state
        cmd_only(8'h21); exp_crc = 16'hFFFF;
        i2c_rd(7'h49, 1); check8("R9 R10 read after clear", rbuf[0], exp_state);
        read_crc();
        xfer(3, 8'hF0);
        read_crc();

        // R11 exit relocks
        cmd_only(8'h24);
        i2c_rd(7'h49, 1); check8("R11 relocked read", rbuf[0], 8'hFF);
        begin
            int f;
            f = cs_falls;
            wbuf[0] = 8'h10; wbuf[1] = 8'h55;
            i2c_wr(7'h49, 2);
            check8("R2 R11 no cs after exit", 8'(cs_falls - f), 8'h00);
        end
        load_key(); i2c_wr(7'h49, 5);
        read_crc();

        summary();
    end
endmodule